// File: doc/BRIEF.md
# Two-Input Ones-Count Modulo-4 Detector

This block is a clocked Moore state machine. It watches two single-bit data inputs. On every clock edge it adds the number of inputs that are high to a running tally. The tally is 0, 1 or 2 per cycle and wraps modulo 4. The registered output is high whenever the total number of ones seen since the last reset is a multiple of four. A downstream unit can use it as a cheap parity-of-four flag on a pair of event strobes.

The parameter `ENC` selects one of three state encodings. The port list and the visible behaviour stay the same for all three, except for the one idle cycle that the third variant adds:

- **0:** a two-bit Gray (K-map ordered) code.
- **1:** a four-bit one-hot code.
- **2:** a one-hot code whose reset state is all zeros. This idle state steps into the first counting state on the first clock edge after reset is released.

Reset is synchronous and active-low. No power-up flop value is relied on.

Top module: `ones_mod4_detect`

## Requirements
- R1: On each clock edge outside reset, the tally advances by the number of high inputs. The step is 0 for in_a/in_b = 00, 1 for 01 or 10, and 2 for 11, and the tally wraps modulo 4.
- R2: After any clock edge at which rst_n is sampled low, zero_mod4 is 1 for every encoding.
- R3: zero_mod4 is 1 exactly when the tally is 0. It is a Moore output, so it changes only after a clock edge, never combinationally from the inputs.
- R4: An edge with in_a = in_b = 0 leaves the state and zero_mod4 unchanged.
- R5: With ENC = 0, the state is two flops coded S0 = 00, S1 = 01, S2 = 11, S3 = 10. zero_mod4 is high when both flops are 0.
- R6: With ENC = 1, the state is four flops coded S0 = 0001, S1 = 0010, S2 = 0100, S3 = 1000. zero_mod4 equals the S0 flop, and reset loads 0001.
- R7: With ENC = 2, reset loads 0000 and zero_mod4 is 1 in that state. The first edge after reset release moves to S0 (0001) and ignores in_a and in_b, so counting starts on the following edge.
- R8: In the one-hot encodings, any state pattern that is not a legal code returns to S0 (0001) on the next edge, regardless of the inputs. Illegal means more than one bit set, or all zeros when ENC = 1.
- R9: Asserting rst_n low mid-count returns the machine to its reset state at the next edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_a | input | 1 | First counted data bit |
| in_b | input | 1 | Second counted data bit |
| zero_mod4 | output | 1 | High when the ones tally since reset is a multiple of four |

## Verification
Two things can fall on one edge.

The first is a double step (both inputs high) taken from the zero state. It must wrap through two codes in a single edge. Random stimulus produces it often, and it is judged by comparing the output against a bench tally that adds both bits at once.

The second is specific to the idle-reset variant: the edge that leaves the idle state coincides with both inputs high. The bench drives 11 on exactly that edge. It then expects the output to stay at 1 for one more cycle and the first step to land one edge later.

Illegal one-hot patterns are forced into the state register together with active inputs. On the next edge, recovery must win over counting.

// File: rtl/onesdet_pkg.sv
// Shared constants and helpers for the ones-count modulo-4 detector.
// Assumes a four-state machine; the Gray helpers work on two-bit values.
package onesdet_pkg;

    localparam int NSTATES  = 4;
    localparam int TALLY_W  = $clog2(NSTATES);

    localparam int ENC_GRAY     = 0;
    localparam int ENC_HOT      = 1;
    localparam int ENC_HOT_IDLE = 2;

    typedef logic [TALLY_W-1:0] tally_t;

    // Convert a binary tally into its reflected Gray code.
    function automatic tally_t bin_to_gray(input tally_t b);
        return b ^ (b >> 1);
    endfunction

    // Convert a reflected Gray code back into a binary tally.
    function automatic tally_t gray_to_bin(input tally_t g);
        tally_t b;
        b[TALLY_W-1] = g[TALLY_W-1];
        for (int i = TALLY_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/onesdet_tally.sv
// Counts how many of the two data bits are high.
// Output is 0, 1 or 2; it is purely combinational.
module onesdet_tally
    import onesdet_pkg::*;
(
    input  logic   bit_a,
    input  logic   bit_b,
    output tally_t step
);

    // Half-adder: the carry is the "2" weight and the sum is the "1" weight.
    always_comb begin
        step    = '0;
        step[1] = bit_a & bit_b;
        step[0] = bit_a ^ bit_b;
    end

endmodule

// File: rtl/onesdet_gray_next.sv
// Next-state and output decode for the two-flop Gray-ordered encoding.
// Every two-bit pattern is a legal state, so no recovery path is needed.
module onesdet_gray_next
    import onesdet_pkg::*;
(
    input  tally_t cur,
    input  tally_t step,
    output tally_t nxt,
    output logic   is_zero
);

    tally_t bin_now;
    tally_t bin_nxt;

    // Decode to binary, add the step modulo 4, and re-encode.
    always_comb begin
        bin_now = gray_to_bin(cur);
        bin_nxt = bin_now + step;
        nxt     = bin_to_gray(bin_nxt);
        is_zero = (cur == '0);
    end

endmodule

// File: rtl/onesdet_hot_next.sv
// Next-state and output decode for the one-hot encodings.
// IDLE_OK = 1 makes the all-zero pattern a legal idle state that holds a
// zero tally; otherwise all-zero is illegal. Illegal codes recover to S0.
module onesdet_hot_next
    import onesdet_pkg::*;
#(
    parameter bit IDLE_OK = 1'b0,
    parameter int N       = NSTATES
) (
    input  logic [N-1:0] cur,
    input  tally_t       step,
    output logic [N-1:0] nxt,
    output logic         is_zero
);

    localparam logic [N-1:0] S0_CODE = N'(1);

    logic           legal;
    logic           idle;
    logic [2*N-1:0] dbl;

    // Classify the current pattern as idle, legal or illegal.
    always_comb begin
        idle  = IDLE_OK && (cur == '0);
        legal = $onehot(cur);
    end

    // Rotate the hot bit left by the step; idle or illegal states enter S0.
    always_comb begin
        dbl = {cur, cur} << step;
        if (idle || !legal) begin
            nxt = S0_CODE;
        end else begin
            nxt = dbl[2*N-1:N];
        end
    end

    // The zero-tally flag: the S0 flop, or the idle state.
    always_comb begin
        is_zero = cur[0] | idle;
    end

endmodule

// File: rtl/ones_mod4_detect.sv
// Moore detector: high when the count of ones on in_a/in_b since reset
// is a multiple of four. ENC picks the state code (0 Gray, 1 one-hot,
// 2 one-hot with all-zero idle reset). Reset is synchronous, active low.
module ones_mod4_detect
    import onesdet_pkg::*;
#(
    parameter int ENC = ENC_GRAY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    output logic zero_mod4
);

    localparam int SW = (ENC == ENC_GRAY) ? TALLY_W : NSTATES;
    localparam logic [SW-1:0] RST_CODE = (ENC == ENC_HOT) ? SW'(1) : '0;

    tally_t        step;
    logic [SW-1:0] state_q;
    logic [SW-1:0] state_d;
    logic          zero_w;

    onesdet_tally u_tally (
        .bit_a (in_a),
        .bit_b (in_b),
        .step  (step)
    );

    generate
        if (ENC == ENC_GRAY) begin : g_gray
            onesdet_gray_next u_next (
                .cur     (state_q),
                .step    (step),
                .nxt     (state_d),
                .is_zero (zero_w)
            );
        end else begin : g_hot
            onesdet_hot_next #(
                .IDLE_OK (ENC == ENC_HOT_IDLE),
                .N       (NSTATES)
            ) u_next (
                .cur     (state_q),
                .step    (step),
                .nxt     (state_d),
                .is_zero (zero_w)
            );
        end
    endgenerate

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RST_CODE;
        end else begin
            state_q <= state_d;
        end
    end

    // Moore output: decoded from the state flops only.
    always_comb begin
        zero_mod4 = zero_w;
    end

endmodule

// File: rtl/ones_mod4_detect_chk.sv
// Property checker for ones_mod4_detect, attached via bind.
// Assumes the state vector and ENC of the bound instance are visible.
module ones_mod4_detect_chk #(
    parameter int ENC = 0,
    parameter int SW  = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a,
    input logic          b,
    input logic          z,
    input logic [SW-1:0] state
);

    localparam bit IDLE = (ENC == 2);

    logic past_valid = 1'b0;

    // Marks that at least one edge has been seen, so $past is meaningful.
    always_ff @(posedge clk) past_valid <= 1'b1;

    // R2: the first cycle after reset always reports a zero tally.
    a_r2_reset_z: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && !$past(rst_n)) |-> z);

    // R4: no ones on an edge keeps a zero tally at zero.
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (z && !a && !b) |=> z);

    // R1: a single one from a zero tally (not the idle step) leaves zero.
    a_r1_single_leaves_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (z && (a ^ b) && !(IDLE && state == '0)) |=> !z);

    generate
        if (ENC != 0) begin : g_hot_chk
            // R8: any non-one-hot pattern (incl. idle) enters S0 next edge.
            a_r8_recover: assert property (@(posedge clk) disable iff (!rst_n)
                ($countones(state) != 1) |=> (state == SW'(1)));
        end
    endgenerate

endmodule

bind ones_mod4_detect ones_mod4_detect_chk #(.ENC(ENC), .SW(SW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (in_a),
    .b     (in_b),
    .z     (zero_mod4),
    .state (state_q)
);

// File: tb/ones_mod4_detect_tb_top.sv
`timescale 1ns/1ps
// Bench: runs all three encodings side by side on shared stimulus and
// compares each output against a bench tally model every cycle.
module ones_mod4_detect_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_a = 1'b0;
    logic in_b = 1'b0;
    logic [2:0] zq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int cnt [3];
    bit idle [3];

    always #2.5 clk = ~clk;

    for (genvar e = 0; e < 3; e++) begin : g_enc
        ones_mod4_detect #(.ENC(e)) dut_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_a      (in_a),
            .in_b      (in_b),
            .zero_mod4 (zq[e])
        );
    end

    function automatic string enc_tag(input int e);
        return (e == 0) ? "R5" : (e == 1) ? "R6" : "R7";
    endfunction

    // Reference: state of the tally after the next edge.
    function automatic int next_cnt(input int c, input bit id, input bit a, input bit b);
        if (id) return 0;
        return (c + int'(a) + int'(b)) % 4;
    endfunction

    task automatic model_reset();
        for (int e = 0; e < 3; e++) begin
            cnt[e]  = 0;
            idle[e] = (e == 2);
        end
    endtask

    task automatic check_all(input string tag);
        for (int e = 0; e < 3; e++) begin
            logic exp_z;
            exp_z = (cnt[e] == 0);
            checks++;
            if (zq[e] !== exp_z) begin
                fails++;
                $display("FAIL %s %s enc=%0d t=%0t z=%b expected=%b",
                         tag, enc_tag(e), e, $time, zq[e], exp_z);
            end
        end
    endtask

    // One cycle: check the outputs at the falling edge, then drive inputs
    // for the next rising edge and advance the model.
    task automatic cycle(input string tag, input bit a, input bit b, input bit rn);
        @(negedge clk);
        check_all(tag);
        in_a  = a;
        in_b  = b;
        rst_n = rn;
        if (!rn) begin
            model_reset();
        end else begin
            for (int e = 0; e < 3; e++) begin
                cnt[e]  = next_cnt(cnt[e], idle[e], a, b);
                idle[e] = 1'b0;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired t=%0t got=running expected=finished", $time);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        // R2: reset state, R9: inputs high during reset do not matter.
        cycle("R9", 1'b1, 1'b1, 1'b0);
        cycle("R2", 1'b1, 1'b1, 1'b1);   // R7: idle exit ignores 11
        cycle("R7", 1'b0, 1'b0, 1'b1);   // R4: no ones
        cycle("R4", 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) cycle("R3", 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) cycle("R1", 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) cycle("R1", 1'b1, 1'b1, 1'b1);
        cycle("R9", 1'b1, 1'b0, 1'b0);   // mid-count reset with a one
        cycle("R9", 1'b1, 1'b1, 1'b1);
        cycle("R7", 1'b1, 1'b1, 1'b1);

        // R8: force illegal one-hot codes with both inputs high.
        @(negedge clk);
        check_all("R8");
        force g_enc[1].dut_i.state_q = 4'b0110;
        force g_enc[2].dut_i.state_q = 4'b1100;
        in_a = 1'b1;
        in_b = 1'b1;
        cnt[0] = next_cnt(cnt[0], 1'b0, 1'b1, 1'b1);
        cnt[1] = 0;
        cnt[2] = 0;
        #1;
        release g_enc[1].dut_i.state_q;
        release g_enc[2].dut_i.state_q;
        cycle("R8", 1'b0, 1'b1, 1'b1);

        // Constrained random traffic with occasional resets.
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom;
            cycle("R3", r[0], r[1], (r[15:8] > 8'd3));
        end
        @(negedge clk);
        check_all("R3");
        finish_run();
    end

endmodule